// File: doc/BRIEF.md
# Channel Accumulator Command Unit

This block sits behind a pointwise activation stage and keeps one running sum per output channel. Each accepted element brings a channel number, a signed 32-bit fixed-point value and a 2-bit command. The command decides whether the channel's sum is left alone, restarted from the value, added to, or restarted from an immediate seed plus the value. Every accepted element is also passed on unchanged on a pointwise write port one cycle later, whatever the command.

A one-cycle drain request streams the channel sums out over a valid/ready port. Only channels whose valid bit is set are sent, lowest index first, and the last beat is marked. Each channel's valid bit clears as its beat is taken. New elements are held off while a drain runs. Three illegal cases raise one-cycle error pulses and change no state: a seeded command without a seed, a seed whose lane count differs from the channel count, and a drain request when no channel holds a sum.

Top module: `chan_accum`

## Requirements
- R1: Command 0 (idle) leaves every channel sum and valid bit unchanged. Every accepted element (inValid and inReady high at a clock edge), whatever its command, appears on wrData with wrValid high in the following cycle.
- R2: Command 1 replaces the channel's sum with the incoming value and sets that channel's valid bit. The old contents have no effect.
- R3: Command 2 adds the incoming value to the channel's current sum and does not change its valid bit.
- R4: Command 3 with seedValid high and seedLanes equal to the channel count sets the sum to seedData plus the incoming value and sets the valid bit.
- R5: Command 3 with seedValid low raises errNoSeed for exactly the next cycle and changes no sum or valid bit.
- R6: Command 3 with seedValid high and seedLanes not equal to the channel count raises errLanes for exactly the next cycle and changes no sum or valid bit.
- R7: Every addition saturates: a sum above 2^31-1 gives 0x7FFFFFFF, and a sum below -2^31 gives 0x80000000.
- R8: A drain request with at least one valid channel starts a drain in the next cycle. The drain sends each valid channel once, in ascending index order, on drChan/drData. drLast is high only on the final beat. While drReady is low the beat is held stable. drValid falls after the last beat is taken.
- R9: A channel's valid bit is cleared when its drain beat is taken, so a second drain with no new commands finds nothing.
- R10: inReady is low while a drain runs and in any cycle where drainReq is high. An element offered then has no effect and gives no pointwise write.
- R11: A drain request when no channel is valid raises errEmpty for exactly the next cycle and starts no drain.
- R12: After reset, all sums are zero, no channel is valid, inReady is high, and drValid, wrValid and all error outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Element offered |
| inReady | output | 1 | Element can be accepted |
| inCmd | input | 2 | 0 idle, 1 restart, 2 add, 3 seed then add |
| inChan | input | 3 | Channel index |
| inData | input | 32 | Signed element value |
| seedValid | input | 1 | Seed present for command 3 |
| seedData | input | 32 | Signed seed value |
| seedLanes | input | 4 | Lane count carried by the seed |
| wrValid | output | 1 | Pointwise write valid |
| wrData | output | 32 | Pointwise write value |
| errNoSeed | output | 1 | Seeded command lacked a seed |
| errLanes | output | 1 | Seed lane count mismatch |
| drainReq | input | 1 | Start a drain |
| errEmpty | output | 1 | Drain requested with nothing accumulated |
| drValid | output | 1 | Drain beat valid |
| drReady | input | 1 | Drain beat taken |
| drChan | output | 3 | Channel of the drain beat |
| drData | output | 32 | Sum of the drain beat |
| drLast | output | 1 | Final drain beat |

## Verification
The assertions watch the handshake rules on every cycle. They check that inputs are held off while a drain is active, that a stalled drain beat stays stable, that the stream stops after the last beat, that each pointwise write and error pulse follows the element that caused it, and that an empty-drain error never comes with a drain. The arithmetic cannot be shown by the assertions: the sum each command leaves behind, saturation at both limits, that a refused seeded command changes nothing, and the ascending choice of valid channels. Only the bench scenarios show these, by draining the sums and comparing them with a reference model kept in the bench.

// File: rtl/chan_accum_pkg.sv
package chan_accum_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE = 2'd0,
    CMD_ZERO = 2'd1,
    CMD_ADD  = 2'd2,
    CMD_SEED = 2'd3
  } acc_cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch element onto pointwise port
    logic accWr;     // write channel sum
    logic addOld;    // base is current sum
    logic addSeed;   // base is the seed
    logic setValid;  // mark channel valid
    logic drainPop;  // drain beat taken
  } acc_strobe_t;

endpackage

// File: rtl/chan_accum_ctrl.sv
module chan_accum_ctrl
  import chan_accum_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        inCmd,
  input  logic              seedValid,
  input  logic [LANE_W-1:0] seedLanes,
  input  logic              drainReq,
  input  logic              drReady,
  input  logic              anyValid,
  input  logic              lastValid,
  output logic              inReady,
  output logic              drValid,
  output logic              wrValid,
  output logic              errNoSeed,
  output logic              errLanes,
  output logic              errEmpty,
  output acc_strobe_t       stb
);

  logic draining;
  logic accept, seedOk, isSeed, isZero, drainStart;

  assign inReady    = !draining && !drainReq;
  assign drValid    = draining;
  assign accept     = inValid && inReady;
  assign isSeed     = acc_cmd_e'(inCmd) == CMD_SEED;
  assign isZero     = acc_cmd_e'(inCmd) == CMD_ZERO;
  assign seedOk     = seedValid && (seedLanes == LANE_W'(NUM_CH));
  assign drainStart = drainReq && !draining && anyValid;

  always_comb begin
    stb          = '0;
    stb.capture  = accept;
    stb.addOld   = acc_cmd_e'(inCmd) == CMD_ADD;
    stb.addSeed  = isSeed;
    stb.accWr    = accept && (isZero || stb.addOld || (isSeed && seedOk));
    stb.setValid = accept && (isZero || (isSeed && seedOk));
    stb.drainPop = draining && drReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      draining  <= 1'b0;
      wrValid   <= 1'b0;
      errNoSeed <= 1'b0;
      errLanes  <= 1'b0;
      errEmpty  <= 1'b0;
    end else begin
      if (drainStart)
        draining <= 1'b1;
      else if (stb.drainPop && lastValid)
        draining <= 1'b0;
      wrValid   <= accept;
      errNoSeed <= accept && isSeed && !seedValid;
      errLanes  <= accept && isSeed && seedValid && !seedOk;
      errEmpty  <= drainReq && !draining && !anyValid;
    end
  end

endmodule

// File: rtl/chan_accum_dp.sv
module chan_accum_dp
  import chan_accum_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  parameter int CH_W   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  acc_strobe_t              stb,
  input  logic [CH_W-1:0]          inChan,
  input  logic signed [DATA_W-1:0] inData,
  input  logic signed [DATA_W-1:0] seedData,
  output logic                     anyValid,
  output logic                     lastValid,
  output logic [CH_W-1:0]          drChan,
  output logic signed [DATA_W-1:0] drData,
  output logic signed [DATA_W-1:0] wrData
);

  localparam logic signed [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] accReg [NUM_CH];
  logic [NUM_CH-1:0]        chValid;
  logic signed [DATA_W-1:0] base, satSum;
  logic signed [DATA_W:0]   wideSum;
  logic [CH_W-1:0]          curIdx;

  always_comb begin
    if (stb.addOld)       base = accReg[inChan];
    else if (stb.addSeed) base = seedData;
    else                  base = '0;
    wideSum = {base[DATA_W-1], base} + {inData[DATA_W-1], inData};
    if (wideSum[DATA_W] != wideSum[DATA_W-1])
      satSum = wideSum[DATA_W] ? MIN_V : MAX_V;
    else
      satSum = wideSum[DATA_W-1:0];
  end

  // lowest valid channel feeds the drain port
  always_comb begin
    curIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (chValid[i]) curIdx = CH_W'(i);
  end

  assign anyValid  = |chValid;
  assign lastValid = anyValid && ((chValid & (chValid - 1'b1)) == '0);
  assign drChan    = curIdx;
  assign drData    = accReg[curIdx];

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk) begin
        if (!rstN) begin
          accReg[g]  <= '0;
          chValid[g] <= 1'b0;
        end else begin
          if (stb.accWr && inChan == CH_W'(g))
            accReg[g] <= satSum;
          if (stb.setValid && inChan == CH_W'(g))
            chValid[g] <= 1'b1;
          else if (stb.drainPop && curIdx == CH_W'(g))
            chValid[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)            wrData <= '0;
    else if (stb.capture) wrData <= inData;
  end

endmodule

// File: rtl/chan_accum.sv
module chan_accum
  import chan_accum_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 32,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int LANE_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [1:0]        inCmd,
  input  logic [CH_W-1:0]   inChan,
  input  logic [DATA_W-1:0] inData,
  input  logic              seedValid,
  input  logic [DATA_W-1:0] seedData,
  input  logic [LANE_W-1:0] seedLanes,
  output logic              wrValid,
  output logic [DATA_W-1:0] wrData,
  output logic              errNoSeed,
  output logic              errLanes,
  input  logic              drainReq,
  output logic              errEmpty,
  output logic              drValid,
  input  logic              drReady,
  output logic [CH_W-1:0]   drChan,
  output logic [DATA_W-1:0] drData,
  output logic              drLast
);

  acc_strobe_t stb;
  logic anyValid, lastValid;

  chan_accum_ctrl #(.NUM_CH(NUM_CH), .LANE_W(LANE_W)) i_ctrl (
    .clk, .rstN, .inValid, .inCmd, .seedValid, .seedLanes, .drainReq, .drReady,
    .anyValid, .lastValid, .inReady, .drValid, .wrValid, .errNoSeed, .errLanes,
    .errEmpty, .stb
  );

  chan_accum_dp #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) i_dp (
    .clk, .rstN, .stb, .inChan, .inData, .seedData, .anyValid, .lastValid,
    .drChan, .drData, .wrData
  );

  assign drLast = drValid && lastValid;

endmodule

// File: rtl/chan_accum_chk.sv
module chan_accum_chk #(
  parameter int DATA_W = 32,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic [1:0]        inCmd,
  input logic [DATA_W-1:0] inData,
  input logic              seedValid,
  input logic              wrValid,
  input logic [DATA_W-1:0] wrData,
  input logic              errNoSeed,
  input logic              errEmpty,
  input logic              drainReq,
  input logic              drValid,
  input logic              drReady,
  input logic [CH_W-1:0]   drChan,
  input logic [DATA_W-1:0] drData,
  input logic              drLast
);

  // R10
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drValid || drainReq) |-> !inReady);

  // R8
  stall_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drValid && !drReady) |=> (drValid && $stable(drChan) && $stable(drData) && $stable(drLast)));

  // R8
  last_ends_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drValid && drReady && drLast) |=> !drValid);

  // R1
  pointwise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (wrValid && wrData == $past(inData)));

  // R10
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(inValid && inReady) |=> !wrValid);

  // R5
  no_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inCmd == 2'd3 && !seedValid) |=> errNoSeed);

  // R11
  empty_no_drain_chk: assert property (@(posedge clk) disable iff (!rstN)
    errEmpty |-> !drValid);

endmodule

bind chan_accum chan_accum_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) i_chk (.*);

// File: tb/test_chan_accum.sv
`timescale 1ns/1ps
module test_chan_accum;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid, inReady;
  logic [1:0]  inCmd;
  logic [2:0]  inChan;
  logic [31:0] inData;
  logic        seedValid;
  logic [31:0] seedData;
  logic [3:0]  seedLanes;
  logic        wrValid;
  logic [31:0] wrData;
  logic        errNoSeed, errLanes, drainReq, errEmpty;
  logic        drValid, drReady, drLast;
  logic [2:0]  drChan;
  logic [31:0] drData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  chan_accum i_chan_accum (.*);

  typedef struct packed {
    logic [1:0]  cmd;
    logic [2:0]  ch;
    logic [31:0] data;
    logic        sv;
    logic [31:0] seed;
    logic [3:0]  lanes;
    logic        eNs;
    logic        eLn;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 3'd2, 32'd100,        1'b0, 32'd0,    4'd0, 1'b0, 1'b0},  // R2
    '{2'd2, 3'd2, 32'd50,         1'b0, 32'd0,    4'd0, 1'b0, 1'b0},  // R3
    '{2'd0, 3'd2, 32'd7,          1'b0, 32'd0,    4'd0, 1'b0, 1'b0},  // R1
    '{2'd3, 3'd5, 32'd10,         1'b1, 32'd1000, 4'd8, 1'b0, 1'b0},  // R4
    '{2'd3, 3'd6, 32'd5,          1'b0, 32'd0,    4'd8, 1'b1, 1'b0},  // R5
    '{2'd3, 3'd6, 32'd5,          1'b1, 32'd9,    4'd4, 1'b0, 1'b1},  // R6
    '{2'd1, 3'd7, 32'h7FFF_FFF0,  1'b0, 32'd0,    4'd0, 1'b0, 1'b0},
    '{2'd2, 3'd7, 32'h0000_0100,  1'b0, 32'd0,    4'd0, 1'b0, 1'b0},  // R7 high
    '{2'd1, 3'd0, 32'h8000_0010,  1'b0, 32'd0,    4'd0, 1'b0, 1'b0},
    '{2'd2, 3'd0, 32'hFFFF_FF00,  1'b0, 32'd0,    4'd0, 1'b0, 1'b0},  // R7 low
    '{2'd2, 3'd0, 32'd5,          1'b0, 32'd0,    4'd0, 1'b0, 1'b0}
  };

  logic [31:0] mAcc [8];
  bit          mValid [8];

  function automatic logic [31:0] satAdd(input logic [31:0] a, input logic [31:0] b);
    longint s = longint'($signed(a)) + longint'($signed(b));
    if (s > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic applyOp(input vec_t v);
    inValid = 1'b1; inCmd = v.cmd; inChan = v.ch; inData = v.data;
    seedValid = v.sv; seedData = v.seed; seedLanes = v.lanes;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0; seedValid = 1'b0;
    check(wrValid && wrData == v.data, "R1 pointwise write", {wrValid, wrData}, {1'b1, v.data});
    check(errNoSeed == v.eNs, "R5 errNoSeed", errNoSeed, v.eNs);
    check(errLanes == v.eLn, "R6 errLanes", errLanes, v.eLn);
    // reference model
    case (v.cmd)
      2'd1: begin mAcc[v.ch] = v.data; mValid[v.ch] = 1'b1; end
      2'd2: mAcc[v.ch] = satAdd(mAcc[v.ch], v.data);
      2'd3: if (v.sv && v.lanes == 4'd8) begin
              mAcc[v.ch] = satAdd(v.seed, v.data); mValid[v.ch] = 1'b1;
            end
      default: ;
    endcase
  endtask

  task automatic doDrain(input int stall, input bit poke);
    logic [2:0]  eCh [8];
    logic [31:0] eD  [8];
    int n = 0;
    for (int c = 0; c < 8; c++) if (mValid[c]) begin eCh[n] = 3'(c); eD[n] = mAcc[c]; n++; end
    drReady = 1'b0; drainReq = 1'b1;
    #1;
    check(!inReady, "R10 inReady low with drainReq", inReady, 0);
    @(posedge clk); @(negedge clk);
    drainReq = 1'b0;
    if (n == 0) begin
      check(errEmpty && !drValid, "R11 empty drain", {errEmpty, drValid}, 2'b10);
      @(posedge clk); @(negedge clk);
      check(!errEmpty && !drValid, "R11 single pulse", {errEmpty, drValid}, 0);
      return;
    end
    check(!errEmpty, "R11 no error when sums held", errEmpty, 0);
    for (int k = 0; k < n; k++) begin
      check(drValid && drChan == eCh[k] && drData == eD[k] && drLast == (k == n - 1),
            "R8 drain beat", {drValid, drLast, drChan, drData}, {1'b1, (k == n - 1), eCh[k], eD[k]});
      if (k == 0) begin
        for (int s = 0; s < stall; s++) begin
          if (poke && s == 0) begin
            inValid = 1'b1; inCmd = 2'd1; inChan = 3'd3; inData = 32'd77;
            #1;
            check(!inReady, "R10 inReady low while draining", inReady, 0);
          end
          @(posedge clk); @(negedge clk);
          if (poke && s == 0) begin
            inValid = 1'b0;
            check(!wrValid, "R10 held-off element not written", wrValid, 0);
          end
          check(drValid && drChan == eCh[0] && drData == eD[0], "R8 stalled beat stable",
                {drChan, drData}, {eCh[0], eD[0]});
        end
      end
      drReady = 1'b1;
      @(posedge clk); @(negedge clk);
      drReady = 1'b0;
      mValid[eCh[k]] = 1'b0;
    end
    check(!drValid && inReady, "R8 drain ends", {drValid, inReady}, 2'b01);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inCmd = '0; inChan = '0; inData = '0;
    seedValid = 1'b0; seedData = '0; seedLanes = '0; drainReq = 1'b0; drReady = 1'b0;
    for (int c = 0; c < 8; c++) begin mAcc[c] = '0; mValid[c] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    check(inReady && !drValid && !wrValid && !errNoSeed && !errLanes && !errEmpty,
          "R12 reset outputs", {inReady, drValid, wrValid, errNoSeed, errLanes, errEmpty}, 6'b100000);
    doDrain(0, 1'b0);   // R12 nothing valid after reset, R11

    for (int i = 0; i < NV; i++) applyOp(VECS[i]);
    doDrain(2, 1'b1);   // R8 ascending with stall, R10 hold-off, R7 results
    doDrain(0, 1'b0);   // R9 valid cleared, R10 poked element ignored

    // R3 add keeps valid bit clear
    applyOp('{2'd2, 3'd2, 32'd4, 1'b0, 32'd0, 4'd0, 1'b0, 1'b0});
    doDrain(0, 1'b0);
    // R2 restart discards old sum; R4 seed path again
    applyOp('{2'd1, 3'd2, 32'd3, 1'b0, 32'd0, 4'd0, 1'b0, 1'b0});
    applyOp('{2'd3, 3'd1, 32'hFFFF_FFFE, 1'b1, 32'd20, 4'd8, 1'b0, 1'b0});
    applyOp('{2'd0, 3'd1, 32'd999, 1'b0, 32'd0, 4'd0, 1'b0, 1'b0});  // R1 idle
    doDrain(1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule